// File: doc/BRIEF.md
# Two-Region Line Migration Allocator

This block moves a cache line out of the write-expensive storage region and into the fast storage region. A migrate request brings the set index, the line's tag, the write-back data and the kind of write-back that triggered it. The kind is either an exclusive-owner eviction or a plain data write-back. The request also names the way in the expensive region that held the line. The block searches the fast-region ways of that set for an empty way. If all ways are occupied, it takes the least recently used way as the victim. A dirty victim is written back to memory before its way is reused.

Once a way is free, the block writes the tag and data into it. It then emits a one-cycle invalidate for the source entry in the expensive region and a one-cycle completion that names the way and the clean state the new line takes. Recency is kept per set with one age counter per way. Installs refresh it, and so do hit notifications that arrive on a separate touch input. Only one migration is handled at a time, and the ready signal stays low while it is in progress.

Top module: `mig_region_mover`

## Requirements
- R1: After reset `mig_ready` is 1, and `wb_valid`, `inv_valid` and `done_valid` are 0.
- R2: A request is taken on a clock edge where `mig_valid` and `mig_ready` are both 1. `mig_ready` is then 0 from the next cycle until the cycle in which `done_valid` is 1, and `done_valid` lasts exactly one cycle.
- R3: If the requested set has at least one empty fast-region way, the lowest-numbered empty way is used (way 0 first). Recency has no effect on this choice.
- R4: If every way of the set is valid, the victim is the way whose last install or touch is the oldest.
- R5: A victim that holds modified data produces exactly one write-back on `wb_valid`/`wb_ready`, carrying the victim's tag, set and data. A clean or empty victim produces none.
- R6: While `wb_valid` is 1 and `wb_ready` is 0, `wb_valid`, `wb_tag`, `wb_set` and `wb_data` hold steady. `done_valid` does not rise until the write-back has been accepted.
- R7: `done_set` and `done_way` name the way that received the line. `done_state` is 2'b10 (clean, acting as modified) when `mig_putx`=1, and 2'b01 (clean, acting as shared) when `mig_putx`=0. Only lines installed with `mig_putx`=1 count as modified when they are later evicted.
- R8: In the same cycle as `done_valid`, `inv_valid` is 1, with `inv_set` equal to the request's set and `inv_way` equal to `mig_src_way`.
- R9: A one-cycle pulse on `acc_valid` makes way `acc_way` of set `acc_set` the most recently used way of that set. A touch in the same cycle as an install is dropped.
- R10: Each set keeps its own recency and occupancy. A migration into one set does not change victim choice in any other set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mig_valid | input | 1 | Migrate request present |
| mig_ready | output | 1 | Block idle and able to take a request |
| mig_set | input | SET_W | Set index of the line |
| mig_tag | input | TAG_W | Tag copied from the expensive-region entry |
| mig_data | input | DATA_W | Write-back data to install |
| mig_putx | input | 1 | 1: owner eviction trigger, 0: plain data write-back |
| mig_src_way | input | SRC_W | Expensive-region way that held the line |
| acc_valid | input | 1 | Recency touch strobe |
| acc_set | input | SET_W | Set of the touched way |
| acc_way | input | WAY_W | Fast-region way touched |
| wb_valid | output | 1 | Victim write-back offered to memory |
| wb_ready | input | 1 | Memory accepts the write-back |
| wb_set | output | SET_W | Victim set index |
| wb_tag | output | TAG_W | Victim tag |
| wb_data | output | DATA_W | Victim data |
| inv_valid | output | 1 | Invalidate the source entry (one cycle) |
| inv_set | output | SET_W | Set of the entry to invalidate |
| inv_way | output | SRC_W | Expensive-region way to invalidate |
| done_valid | output | 1 | Migration finished (one cycle) |
| done_set | output | SET_W | Set written |
| done_way | output | WAY_W | Fast-region way written |
| done_state | output | 2 | 2'b10 clean as modified, 2'b01 clean as shared |

## Verification
The bench builds the block with 4 sets, 4 fast ways, 4 source ways, 8-bit tags and 16-bit data. With only 4 ways per set, a few requests fill a set. The bench can therefore drive a full rotation of LRU victims, with clean and dirty lines mixed, and check eviction order against a timestamp model. With 4 sets it can also run one set while another is partly empty, which shows that the sets are kept apart. Small tags and data make every victim's write-back contents easy to predict. Memory stalls of several cycles are put on individual evictions to check that the write-back holds steady and that completion waits for it.

// File: rtl/mig_pkg.sv
package mig_pkg;

  // Clean state reported with a completed migration
  typedef enum logic [1:0] {
    FS_NONE     = 2'b00,
    FS_SHARED   = 2'b01,
    FS_MODIFIED = 2'b10
  } fin_state_e;

  // Controller sequence
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_SEL  = 3'd1,
    ST_RDV  = 3'd2,
    ST_WB   = 3'd3,
    ST_INST = 3'd4
  } mig_state_e;

endpackage

// File: rtl/mig_line_store.sv
module mig_line_store #(
  parameter int SETS   = 16,
  parameter int WAYS   = 4,
  parameter int TAG_W  = 20,
  parameter int DATA_W = 64,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [SET_W-1:0]      wr_set,
  input  logic [WAY_W-1:0]      wr_way,
  input  logic [TAG_W-1:0]      wr_tag,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic                  wr_dirty,
  input  logic [SET_W-1:0]      rd_set,
  input  logic [WAY_W-1:0]      rd_way,
  output logic [WAYS-1:0]       rd_valid_vec,
  output logic [WAYS-1:0]       rd_dirty_vec,
  output logic [WAYS*TAG_W-1:0] rd_tag_flat,
  output logic [DATA_W-1:0]     rd_data
);
  localparam int LINES  = SETS * WAYS;
  localparam int ADDR_W = SET_W + WAY_W;

  logic [DATA_W-1:0] data_mem [LINES];
  logic [TAG_W-1:0]  tag_q    [LINES];
  logic [LINES-1:0]  valid_q;
  logic [LINES-1:0]  dirty_q;

  logic [ADDR_W-1:0] waddr, raddr;
  assign waddr = {wr_set, wr_way};
  assign raddr = {rd_set, rd_way};

  // Data array: one synchronous write port and one registered read port, no reset
  always_ff @(posedge clk) begin
    if (wr_en) data_mem[waddr] <= wr_data;
    rd_data <= data_mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[waddr] <= wr_tag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (wr_en) begin
      valid_q[waddr] <= 1'b1;
      dirty_q[waddr] <= wr_dirty;
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_way_rd
    logic [ADDR_W-1:0] idx;
    assign idx = {rd_set, WAY_W'(w)};
    assign rd_valid_vec[w]               = valid_q[idx];
    assign rd_dirty_vec[w]               = dirty_q[idx];
    assign rd_tag_flat[w*TAG_W +: TAG_W] = tag_q[idx];
  end

endmodule

// File: rtl/mig_lru.sv
module mig_lru #(
  parameter int SETS = 16,
  parameter int WAYS = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int AGE_W = WAY_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  touch_en,
  input  logic [SET_W-1:0]      touch_set,
  input  logic [WAY_W-1:0]      touch_way,
  input  logic [SET_W-1:0]      rd_set,
  output logic [WAYS*AGE_W-1:0] ages_flat
);
  // Ages within a set form a permutation of 0..WAYS-1; the highest age is the oldest way
  logic [AGE_W-1:0] age_q [SETS][WAYS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= AGE_W'(w);
    end else if (touch_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way)
          age_q[touch_set][w] <= '0;
        else if (age_q[touch_set][w] < age_q[touch_set][touch_way])
          age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
      end
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_age_rd
    assign ages_flat[w*AGE_W +: AGE_W] = age_q[rd_set][w];
  end

endmodule

// File: rtl/mig_way_pick.sv
module mig_way_pick #(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS),
  localparam int AGE_W = WAY_W
) (
  input  logic [WAYS-1:0]       valid_vec,
  input  logic [WAYS*AGE_W-1:0] ages_flat,
  output logic [WAY_W-1:0]      pick_way,
  output logic                  found_empty
);
  logic [WAY_W-1:0] empty_way, old_way;
  logic [AGE_W-1:0] best_age;

  always_comb begin
    found_empty = 1'b0;
    empty_way   = '0;
    // Scan downwards so that the lowest empty index is the one kept
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_vec[w]) begin
        found_empty = 1'b1;
        empty_way   = WAY_W'(w);
      end
    end
    best_age = '0;
    old_way  = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (ages_flat[w*AGE_W +: AGE_W] >= best_age) begin
        best_age = ages_flat[w*AGE_W +: AGE_W];
        old_way  = WAY_W'(w);
      end
    end
    pick_way = found_empty ? empty_way : old_way;
  end

endmodule

// File: rtl/mig_region_mover.sv
module mig_region_mover
  import mig_pkg::*;
#(
  parameter int SETS     = 16,
  parameter int WAYS     = 4,
  parameter int SRC_WAYS = 8,
  parameter int TAG_W    = 20,
  parameter int DATA_W   = 64,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int SRC_W = $clog2(SRC_WAYS),
  localparam int AGE_W = WAY_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mig_valid,
  output logic              mig_ready,
  input  logic [SET_W-1:0]  mig_set,
  input  logic [TAG_W-1:0]  mig_tag,
  input  logic [DATA_W-1:0] mig_data,
  input  logic              mig_putx,
  input  logic [SRC_W-1:0]  mig_src_way,
  input  logic              acc_valid,
  input  logic [SET_W-1:0]  acc_set,
  input  logic [WAY_W-1:0]  acc_way,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [SET_W-1:0]  wb_set,
  output logic [TAG_W-1:0]  wb_tag,
  output logic [DATA_W-1:0] wb_data,
  output logic              inv_valid,
  output logic [SET_W-1:0]  inv_set,
  output logic [SRC_W-1:0]  inv_way,
  output logic              done_valid,
  output logic [SET_W-1:0]  done_set,
  output logic [WAY_W-1:0]  done_way,
  output logic [1:0]        done_state
);
  mig_state_e st;

  // Request captured on acceptance
  logic [SET_W-1:0]  r_set;
  logic [TAG_W-1:0]  r_tag;
  logic [DATA_W-1:0] r_data;
  logic              r_putx;
  logic [SRC_W-1:0]  r_src;
  logic [WAY_W-1:0]  r_way;
  logic [TAG_W-1:0]  r_vtag;

  logic [WAYS-1:0]       valid_vec, dirty_vec;
  logic [WAYS*TAG_W-1:0] tag_flat;
  logic [WAYS*AGE_W-1:0] ages_flat;
  logic [DATA_W-1:0]     rd_data;
  logic [WAY_W-1:0]      pick_way, rd_way;
  logic                  found_empty;
  logic                  inst_en;
  logic                  touch_en;
  logic [SET_W-1:0]      touch_set;
  logic [WAY_W-1:0]      touch_way;

  assign mig_ready = (st == ST_IDLE);
  assign inst_en   = (st == ST_INST);
  assign rd_way    = (st == ST_SEL) ? pick_way : r_way;

  // An install refresh takes the port; a touch in the same cycle is dropped
  assign touch_en  = inst_en | acc_valid;
  assign touch_set = inst_en ? r_set : acc_set;
  assign touch_way = inst_en ? r_way : acc_way;

  mig_line_store #(
    .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .DATA_W(DATA_W)
  ) u_store (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (inst_en),
    .wr_set       (r_set),
    .wr_way       (r_way),
    .wr_tag       (r_tag),
    .wr_data      (r_data),
    .wr_dirty     (r_putx),
    .rd_set       (r_set),
    .rd_way       (rd_way),
    .rd_valid_vec (valid_vec),
    .rd_dirty_vec (dirty_vec),
    .rd_tag_flat  (tag_flat),
    .rd_data      (rd_data)
  );

  mig_lru #(
    .SETS(SETS), .WAYS(WAYS)
  ) u_lru (
    .clk       (clk),
    .rst       (rst),
    .touch_en  (touch_en),
    .touch_set (touch_set),
    .touch_way (touch_way),
    .rd_set    (r_set),
    .ages_flat (ages_flat)
  );

  mig_way_pick #(
    .WAYS(WAYS)
  ) u_pick (
    .valid_vec   (valid_vec),
    .ages_flat   (ages_flat),
    .pick_way    (pick_way),
    .found_empty (found_empty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      wb_valid   <= 1'b0;
      inv_valid  <= 1'b0;
      done_valid <= 1'b0;
      wb_set     <= '0;
      wb_tag     <= '0;
      wb_data    <= '0;
      inv_set    <= '0;
      inv_way    <= '0;
      done_set   <= '0;
      done_way   <= '0;
      done_state <= FS_NONE;
      r_set      <= '0;
      r_tag      <= '0;
      r_data     <= '0;
      r_putx     <= 1'b0;
      r_src      <= '0;
      r_way      <= '0;
      r_vtag     <= '0;
    end else begin
      inv_valid  <= 1'b0;
      done_valid <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (mig_valid) begin
            r_set  <= mig_set;
            r_tag  <= mig_tag;
            r_data <= mig_data;
            r_putx <= mig_putx;
            r_src  <= mig_src_way;
            st     <= ST_SEL;
          end
        end
        ST_SEL: begin
          r_way  <= pick_way;
          r_vtag <= tag_flat[pick_way*TAG_W +: TAG_W];
          st     <= (!found_empty && dirty_vec[pick_way]) ? ST_RDV : ST_INST;
        end
        ST_RDV: begin
          wb_valid <= 1'b1;
          wb_set   <= r_set;
          wb_tag   <= r_vtag;
          wb_data  <= rd_data;
          st       <= ST_WB;
        end
        ST_WB: begin
          if (wb_ready) begin
            wb_valid <= 1'b0;
            st       <= ST_INST;
          end
        end
        ST_INST: begin
          inv_valid  <= 1'b1;
          inv_set    <= r_set;
          inv_way    <= r_src;
          done_valid <= 1'b1;
          done_set   <= r_set;
          done_way   <= r_way;
          done_state <= r_putx ? FS_MODIFIED : FS_SHARED;
          st         <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mig_region_mover_chk.sv
module mig_region_mover_chk #(
  parameter int SET_W  = 4,
  parameter int TAG_W  = 20,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              mig_valid,
  input logic              mig_ready,
  input logic              wb_valid,
  input logic              wb_ready,
  input logic [SET_W-1:0]  wb_set,
  input logic [TAG_W-1:0]  wb_tag,
  input logic [DATA_W-1:0] wb_data,
  input logic              inv_valid,
  input logic              done_valid,
  input logic [1:0]        done_state
);

  AST_READY_DROP: assert property (@(posedge clk) disable iff (rst)
    mig_valid && mig_ready |=> !mig_ready);  // R2

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_valid |=> !done_valid);  // R2

  AST_WB_HOLD: assert property (@(posedge clk) disable iff (rst)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_data) && $stable(wb_tag) && $stable(wb_set));  // R6

  AST_NO_DONE_IN_WB: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> !done_valid);  // R6

  AST_DONE_ENC: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> (done_state == 2'b01 || done_state == 2'b10));  // R7

  AST_INV_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> inv_valid);  // R8

endmodule

bind mig_region_mover mig_region_mover_chk #(
  .SET_W(SET_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mig_valid  (mig_valid),
  .mig_ready  (mig_ready),
  .wb_valid   (wb_valid),
  .wb_ready   (wb_ready),
  .wb_set     (wb_set),
  .wb_tag     (wb_tag),
  .wb_data    (wb_data),
  .inv_valid  (inv_valid),
  .done_valid (done_valid),
  .done_state (done_state)
);

// File: tb/sim_mig_region_mover.sv
module sim_mig_region_mover;
  localparam int SETS = 4, WAYS = 4, SRC_WAYS = 4, TAG_W = 8, DATA_W = 16;
  localparam int NV = 11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        mig_valid = 0, mig_ready, mig_putx = 0;
  logic [1:0]  mig_set = 0, mig_src_way = 0;
  logic [7:0]  mig_tag = 0;
  logic [15:0] mig_data = 0;
  logic        acc_valid = 0;
  logic [1:0]  acc_set = 0, acc_way = 0;
  logic        wb_valid, wb_ready = 0;
  logic [1:0]  wb_set;
  logic [7:0]  wb_tag;
  logic [15:0] wb_data;
  logic        inv_valid, done_valid;
  logic [1:0]  inv_set, inv_way, done_set, done_way, done_state;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  mig_region_mover #(
    .SETS(SETS), .WAYS(WAYS), .SRC_WAYS(SRC_WAYS), .TAG_W(TAG_W), .DATA_W(DATA_W)
  ) u0 (
    .clk(clk), .rst(rst),
    .mig_valid(mig_valid), .mig_ready(mig_ready), .mig_set(mig_set), .mig_tag(mig_tag),
    .mig_data(mig_data), .mig_putx(mig_putx), .mig_src_way(mig_src_way),
    .acc_valid(acc_valid), .acc_set(acc_set), .acc_way(acc_way),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_set(wb_set), .wb_tag(wb_tag), .wb_data(wb_data),
    .inv_valid(inv_valid), .inv_set(inv_set), .inv_way(inv_way),
    .done_valid(done_valid), .done_set(done_set), .done_way(done_way), .done_state(done_state)
  );

  // {set, tag, data, putx, src, exp_way, exp_wb, exp_wb_tag, exp_wb_data, stall}
  localparam logic [59:0] VEC [NV] = '{
    {2'd1, 8'h10, 16'h1001, 1'b1, 2'd0, 2'd0, 1'b0, 8'h00, 16'h0000, 4'd0},
    {2'd1, 8'h11, 16'h1102, 1'b0, 2'd1, 2'd1, 1'b0, 8'h00, 16'h0000, 4'd0},
    {2'd1, 8'h12, 16'h1203, 1'b1, 2'd2, 2'd2, 1'b0, 8'h00, 16'h0000, 4'd0},
    {2'd1, 8'h13, 16'h1304, 1'b0, 2'd3, 2'd3, 1'b0, 8'h00, 16'h0000, 4'd0},
    {2'd2, 8'h20, 16'h2001, 1'b0, 2'd0, 2'd0, 1'b0, 8'h00, 16'h0000, 4'd0},
    {2'd1, 8'h14, 16'h1405, 1'b0, 2'd1, 2'd0, 1'b1, 8'h10, 16'h1001, 4'd0},
    {2'd1, 8'h15, 16'h1506, 1'b1, 2'd2, 2'd1, 1'b0, 8'h00, 16'h0000, 4'd0},
    {2'd1, 8'h16, 16'h1607, 1'b0, 2'd3, 2'd2, 1'b1, 8'h12, 16'h1203, 4'd2},
    {2'd1, 8'h17, 16'h1708, 1'b1, 2'd0, 2'd3, 1'b0, 8'h00, 16'h0000, 4'd0},
    {2'd1, 8'h18, 16'h1809, 1'b0, 2'd1, 2'd0, 1'b0, 8'h00, 16'h0000, 4'd0},
    {2'd1, 8'h19, 16'h1910, 1'b0, 2'd2, 2'd1, 1'b1, 8'h15, 16'h1506, 4'd4}
  };

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic touch(input logic [1:0] s, input logic [1:0] w);
    @(negedge clk);
    acc_valid = 1; acc_set = s; acc_way = w;
    @(negedge clk);
    acc_valid = 0;
  endtask

  // Runs one migration and checks every visible effect against the expected values
  task automatic migrate(input logic [1:0] s, input logic [7:0] t, input logic [15:0] d,
                         input logic px, input logic [1:0] src, input logic [1:0] ew,
                         input logic ewb, input logic [7:0] ewt, input logic [15:0] ewd,
                         input int stall);
    int  wb_cnt = 0;
    int  st_left = stall;
    bit  seen_wb = 0, got_done = 0, busy_ok = 1, hold_ok = 1, inv_ok = 0;
    logic [7:0]  c_tag = 0;
    logic [15:0] c_data = 0;
    logic [1:0]  c_set = 0, g_set = 0, g_way = 0, g_state = 0, g_iset = 0, g_iway = 0;
    @(negedge clk);
    while (!mig_ready) @(negedge clk);
    mig_valid = 1; mig_set = s; mig_tag = t; mig_data = d; mig_putx = px; mig_src_way = src;
    @(negedge clk);
    mig_valid = 0;
    for (int cyc = 0; cyc < 40; cyc++) begin
      if (done_valid) begin
        got_done = 1;
        g_set = done_set; g_way = done_way; g_state = done_state;
        inv_ok = inv_valid; g_iset = inv_set; g_iway = inv_way;
        break;
      end
      if (mig_ready) busy_ok = 0;
      if (wb_valid) begin
        if (!seen_wb) begin
          seen_wb = 1; c_tag = wb_tag; c_data = wb_data; c_set = wb_set;
        end else if (wb_tag !== c_tag || wb_data !== c_data || wb_set !== c_set) hold_ok = 0;
        if (st_left > 0) begin
          wb_ready = 0; st_left--;
        end else begin
          wb_ready = 1; wb_cnt++;
        end
      end else wb_ready = 0;
      @(negedge clk);
    end
    wb_ready = 0;
    check("R2", "done seen", 32'(got_done), 32'd1);
    check("R2", "ready low while busy", 32'(busy_ok), 32'd1);
    check("R2", "ready high at done", 32'(mig_ready), 32'd1);
    check(ewb ? "R3/R4" : "R3", "chosen way", 32'(g_way), 32'(ew));
    check("R10", "done set", 32'(g_set), 32'(s));
    check("R5", "write-back count", 32'(wb_cnt), 32'(ewb));
    if (ewb) begin
      check("R5", "victim tag", 32'(c_tag), 32'(ewt));
      check("R5", "victim data", 32'(c_data), 32'(ewd));
      check("R5", "victim set", 32'(c_set), 32'(s));
      check("R6", "write-back held under stall", 32'(hold_ok), 32'd1);
    end
    check("R7", "done state", 32'(g_state), px ? 32'd2 : 32'd1);
    check("R8", "inv with done", 32'(inv_ok), 32'd1);
    check("R8", "inv set", 32'(g_iset), 32'(s));
    check("R8", "inv way", 32'(g_iway), 32'(src));
    @(negedge clk);
    check("R2", "done one cycle", 32'(done_valid), 32'd0);
  endtask

  initial begin
    #(5ns * 100000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1", "mig_ready", 32'(mig_ready), 32'd1);
    check("R1", "wb_valid", 32'(wb_valid), 32'd0);
    check("R1", "inv_valid", 32'(inv_valid), 32'd0);
    check("R1", "done_valid", 32'(done_valid), 32'd0);

    // Table: fill, rotate LRU victims, mixed dirty/clean, stalls, second set
    for (int i = 0; i < NV; i++) begin
      migrate(VEC[i][59:58], VEC[i][57:50], VEC[i][49:34], VEC[i][33], VEC[i][32:31],
              VEC[i][30:29], VEC[i][28], VEC[i][27:20], VEC[i][19:4], int'(VEC[i][3:0]));
    end

    // R9: touching way 2 of set 1 moves the victim to way 3 (dirty, tag 17)
    touch(2'd1, 2'd2);
    migrate(2'd1, 8'h1A, 16'h1A0B, 1'b0, 2'd2, 2'd3, 1'b1, 8'h17, 16'h1708, 1);

    // R3/R10: touching an empty way of set 2 does not alter empty-first choice
    touch(2'd2, 2'd3);
    migrate(2'd2, 8'h21, 16'h2102, 1'b1, 2'd1, 2'd1, 1'b0, 8'h00, 16'h0000, 0);

    // R4: after the install above, set 1 victim is way 0 (tag 18, clean)
    migrate(2'd1, 8'h1B, 16'h1B0C, 1'b1, 2'd3, 2'd0, 1'b0, 8'h00, 16'h0000, 0);

    summary();
  end

endmodule